// File: doc/BRIEF.md
# Nine-Bit Multidrop Serial Link

This block sends and receives asynchronous serial characters that carry nine payload bits, as used on shared multidrop buses. The ninth bit tells a station whether a character is an address (1) or data (0). A host feeds the transmitter one byte at a time. The transmitter works in one of two modes, chosen by `tx_mode_arb`:

- **Block mode:** the transmitter marks only the opening character of each block as an address.
- **Per-character mode:** the host supplies every character as a pair of bytes, with the ninth bit first and the low eight bits second.

The receiver turns each accepted character back into a two-byte pair for the host, using the same layout. An optional station filter drops traffic meant for other stations. A plain divisor input sets the bit period in clock cycles.

A typical master sends an address character and then a run of data characters. Every slave sees the address. Only the slave whose local address matches keeps the characters that follow, until the next address character appears on the bus.

Top module: `ninebit_uart`

## Requirements
- R1: The transmit line idles high. Each character is sent as one low start bit, then nine payload bits with bit 0 first and the ninth bit last, then one high stop bit. Every bit lasts `baud_div` clock cycles.
- R2: With `tx_mode_arb`=0, each accepted byte becomes one character. The character after reset, or after a byte accepted with `tx_last`=1, gets ninth bit 1. Every other character gets ninth bit 0.
- R3: With `tx_mode_arb`=1, bytes are taken in pairs. Bit 0 of the first byte is the ninth bit and the second byte is the low eight bits. The character is sent after the second byte is accepted.
- R4: Every delivered character appears as two consecutive `rx_valid` cycles. The first has `rx_first`=1 and `rx_byte` set to 0x00 or 0x01 from the ninth bit. The second has `rx_first`=0 and `rx_byte` set to the low eight bits.
- R5: With `filt_en`=0, every correctly framed character is delivered, whatever its ninth bit.
- R6: With `filt_en`=1, an address character whose low byte equals `my_addr` is delivered. The characters after it are then delivered until the next address character.
- R7: With `filt_en`=1, an address character that does not match is dropped, and so are the data characters after it. After reset, data characters are dropped until a matching address arrives.
- R8: A character whose stop bit is sampled low produces a one-cycle `rx_frame_err` pulse and is not delivered.
- R9: In per-character mode, a first byte of a pair that arrives with `tx_last`=1 is rejected. The block pulses `tx_odd_err` for one cycle and sends nothing. The next byte is taken as the first of a new pair.
- R10: In per-character mode with the filter off, looping back 0x055, 0x155, 0x055 delivers the bytes 00 55 01 55 00 55.
- R11: After reset, `txd` is high, `tx_ready` is high, and `rx_valid`, `tx_odd_err` and `rx_frame_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Bit period in clock cycles (at least 4) |
| tx_mode_arb | input | 1 | 0 = block mode, 1 = per-character pair mode |
| tx_valid | input | 1 | Host offers `tx_byte` |
| tx_byte | input | 8 | Host transmit byte |
| tx_last | input | 1 | Ends a block (block mode); flags an odd request on a pair's first byte |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_odd_err | output | 1 | One-cycle pulse on a rejected odd request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| filt_en | input | 1 | Enables station filtering |
| my_addr | input | 8 | Local station address |
| rx_valid | output | 1 | `rx_byte` holds a received byte |
| rx_first | output | 1 | Marks the ninth-bit byte of a pair |
| rx_byte | output | 8 | Received byte |
| rx_frame_err | output | 1 | One-cycle pulse on a bad stop bit |

## Verification
The bench goes after these corner cases:

- **Data after reset with no address seen.** A filter that starts out open would pass data that should be dropped.
- **A mismatching address followed by data.** A filter that checks the ninth bit on every character, instead of keeping match state, would pass that data.
- **Back-to-back single-character blocks.** A transmitter that only marks the first character after reset would leave the later block starts as data.
- **A lone first half of a pair.** A transmitter that keeps the stray half would shift every later pair by one byte.
- **A character with a low stop bit, and bit order.** A receiver that skips the stop check would deliver garbage. A frame driven straight onto the receive line, not looped back, shows whether the ninth bit lands in the right place.

// File: rtl/nb_pkg.sv
package nb_pkg;

    localparam int FRAME_BITS = 11;   // start + 9 payload + stop
    localparam int PAYLOAD_BITS = 9;

    typedef struct packed {
        logic       addr;   // ninth bit: 1 = address character
        logic [7:0] data;
    } nb_char_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    function automatic logic [7:0] flag_byte(input logic ninth);
        return {7'b0, ninth};
    endfunction

endpackage

// File: rtl/nb_tx.sv
module nb_tx
    import nb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             mode_arb,
    input  logic             tx_valid,
    input  logic [7:0]       tx_byte,
    input  logic             tx_last,
    output logic             tx_ready,
    output logic             tx_odd_err,
    output logic             txd
);
    localparam int NB_W = $clog2(FRAME_BITS + 1);

    logic                  busy;
    logic [FRAME_BITS-1:0] sh;
    logic [DIV_W-1:0]      cnt;
    logic [NB_W-1:0]       nbits;
    logic                  first_blk;
    logic                  half_v;
    logic                  half_b;
    logic                  take;
    logic                  load;
    nb_char_t              ch;

    assign take     = tx_valid && !busy;
    assign tx_ready = !busy;
    assign txd      = sh[0];

    // Decide whether this accepted byte completes a character, and which one.
    always_comb begin
        load = 1'b0;
        ch   = '0;
        if (take) begin
            if (!mode_arb) begin
                load = 1'b1;
                ch   = '{addr: first_blk, data: tx_byte};
            end else if (half_v) begin
                load = 1'b1;
                ch   = '{addr: half_b, data: tx_byte};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            sh         <= '1;
            cnt        <= '0;
            nbits      <= '0;
            first_blk  <= 1'b1;
            half_v     <= 1'b0;
            half_b     <= 1'b0;
            tx_odd_err <= 1'b0;
        end else begin
            tx_odd_err <= 1'b0;
            if (busy) begin
                if (cnt == '0) begin
                    sh  <= {1'b1, sh[FRAME_BITS-1:1]};
                    cnt <= baud_div - DIV_W'(1);
                    if (nbits == NB_W'(FRAME_BITS - 1)) busy <= 1'b0;
                    else nbits <= nbits + NB_W'(1);
                end else begin
                    cnt <= cnt - DIV_W'(1);
                end
            end else if (take) begin
                if (!mode_arb) begin
                    first_blk <= tx_last;
                end else if (!half_v) begin
                    if (tx_last) tx_odd_err <= 1'b1;
                    else begin
                        half_v <= 1'b1;
                        half_b <= tx_byte[0];
                    end
                end else begin
                    half_v <= 1'b0;
                end
                if (load) begin
                    sh    <= {1'b1, ch, 1'b0};
                    busy  <= 1'b1;
                    cnt   <= baud_div - DIV_W'(1);
                    nbits <= '0;
                end
            end
        end
    end

    // R1: a frame always opens with a low start bit on the line
    a_r1_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    // R9: a rejected odd request never launches a frame
    a_r9_odd_silent: assert property (@(posedge clk) disable iff (rst)
        tx_odd_err |=> !busy);

endmodule

// File: rtl/nb_rx.sv
module nb_rx
    import nb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             rxd,
    output logic             char_valid,
    output nb_char_t         char_out,
    output logic             frame_err
);
    localparam int IDX_W = $clog2(PAYLOAD_BITS);

    logic [1:0]              sync;
    logic                    rxs;
    rx_state_e               state;
    logic [DIV_W-1:0]        cnt;
    logic [IDX_W-1:0]        idx;
    logic [PAYLOAD_BITS-1:0] sr;

    assign rxs      = sync[1];
    assign char_out = nb_char_t'(sr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync       <= 2'b11;
            state      <= RX_IDLE;
            cnt        <= '0;
            idx        <= '0;
            sr         <= '0;
            char_valid <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            sync       <= {sync[0], rxd};
            char_valid <= 1'b0;
            frame_err  <= 1'b0;
            if (state == RX_IDLE) begin
                if (!rxs) begin
                    state <= RX_START;
                    cnt   <= baud_div >> 1;   // aim at the middle of the start bit
                end
            end else if (cnt != '0) begin
                cnt <= cnt - DIV_W'(1);
            end else begin
                cnt <= baud_div - DIV_W'(1);
                case (state)
                    RX_START: begin
                        if (rxs) state <= RX_IDLE;   // glitch, not a start bit
                        else begin
                            state <= RX_DATA;
                            idx   <= '0;
                        end
                    end
                    RX_DATA: begin
                        sr <= {rxs, sr[PAYLOAD_BITS-1:1]};
                        if (idx == IDX_W'(PAYLOAD_BITS - 1)) state <= RX_STOP;
                        else idx <= idx + IDX_W'(1);
                    end
                    RX_STOP: begin
                        if (rxs) char_valid <= 1'b1;
                        else frame_err <= 1'b1;
                        state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/nb_filter.sv
module nb_filter
    import nb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       filt_en,
    input  logic [7:0] my_addr,
    input  logic       in_valid,
    input  nb_char_t   in_char,
    output logic       rx_valid,
    output logic       rx_first,
    output logic [7:0] rx_byte
);
    logic       matched;
    logic       pend;
    logic [7:0] hold;
    logic       keep;

    always_comb begin
        if (!filt_en)          keep = 1'b1;
        else if (in_char.addr) keep = (in_char.data == my_addr);
        else                   keep = matched;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            matched  <= 1'b0;
            pend     <= 1'b0;
            hold     <= '0;
            rx_valid <= 1'b0;
            rx_first <= 1'b0;
            rx_byte  <= '0;
        end else begin
            if (in_valid && filt_en && in_char.addr)
                matched <= (in_char.data == my_addr);
            if (in_valid && keep) begin
                rx_valid <= 1'b1;
                rx_first <= 1'b1;
                rx_byte  <= flag_byte(in_char.addr);
                hold     <= in_char.data;
                pend     <= 1'b1;
            end else if (pend) begin
                rx_valid <= 1'b1;
                rx_first <= 1'b0;
                rx_byte  <= hold;
                pend     <= 1'b0;
            end else begin
                rx_valid <= 1'b0;
                rx_first <= 1'b0;
            end
        end
    end

    // R4: the flag byte is always followed at once by the data byte
    a_r4_pair_follows: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_first) |=> (rx_valid && !rx_first));

    // R4: the flag byte only ever carries 0x00 or 0x01
    a_r4_flag_value: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_first) |-> (rx_byte[7:1] == 7'b0));

    // R7: a foreign address produces no output
    a_r7_foreign_drop: assert property (@(posedge clk) disable iff (rst)
        (in_valid && filt_en && in_char.addr && in_char.data != my_addr)
        |=> !rx_valid);

endmodule

// File: rtl/ninebit_uart.sv
module ninebit_uart
    import nb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             tx_mode_arb,
    input  logic             tx_valid,
    input  logic [7:0]       tx_byte,
    input  logic             tx_last,
    output logic             tx_ready,
    output logic             tx_odd_err,
    output logic             txd,
    input  logic             rxd,
    input  logic             filt_en,
    input  logic [7:0]       my_addr,
    output logic             rx_valid,
    output logic             rx_first,
    output logic [7:0]       rx_byte,
    output logic             rx_frame_err
);
    logic     char_valid;
    nb_char_t char_rx;

    nb_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst(rst), .baud_div(baud_div), .mode_arb(tx_mode_arb),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_odd_err(tx_odd_err), .txd(txd)
    );

    nb_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst(rst), .baud_div(baud_div), .rxd(rxd),
        .char_valid(char_valid), .char_out(char_rx), .frame_err(rx_frame_err)
    );

    nb_filter u_filt (
        .clk(clk), .rst(rst), .filt_en(filt_en), .my_addr(my_addr),
        .in_valid(char_valid), .in_char(char_rx),
        .rx_valid(rx_valid), .rx_first(rx_first), .rx_byte(rx_byte)
    );

    // R8: a framing error is never followed by a delivered byte
    a_r8_err_silent: assert property (@(posedge clk) disable iff (rst)
        rx_frame_err |=> !rx_valid);

endmodule

// File: tb/tb_ninebit_uart.sv
module tb_ninebit_uart;

    localparam int DIV   = 8;
    localparam int WAITC = 13 * DIV;

    logic       clk = 0;
    logic       rst = 1;
    logic [15:0] baud_div = 16'(DIV);
    logic       tx_mode_arb = 1'b1;
    logic       tx_valid = 0;
    logic [7:0] tx_byte = 0;
    logic       tx_last = 0;
    logic       tx_ready, tx_odd_err, txd;
    logic       lb = 1'b1;
    logic       tb_rx = 1'b1;
    logic       rxd;
    logic       filt_en = 1'b1;
    logic [7:0] my_addr = 8'h42;
    logic       rx_valid, rx_first, rx_frame_err;
    logic [7:0] rx_byte;

    assign rxd = lb ? txd : tb_rx;

    always #10 clk = ~clk;

    ninebit_uart #(.DIV_W(16)) dut (
        .clk(clk), .rst(rst), .baud_div(baud_div), .tx_mode_arb(tx_mode_arb),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_odd_err(tx_odd_err), .txd(txd), .rxd(rxd),
        .filt_en(filt_en), .my_addr(my_addr), .rx_valid(rx_valid),
        .rx_first(rx_first), .rx_byte(rx_byte), .rx_frame_err(rx_frame_err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [8:0] txlog [0:63];
    int         tx_n = 0;
    logic [7:0] rxq [0:127];
    logic       rxf [0:127];
    int         rx_n = 0;
    int         odd_cnt = 0;
    int         ferr_cnt = 0;

    // {keep, ninth, data}; filter on, local address 0x42, fresh from reset
    localparam logic [9:0] VEC [8] = '{
        10'h010, 10'h342, 10'h233, 10'h2FF,
        10'h177, 10'h055, 10'h342, 10'h200
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Independent line decoder for the transmit pin (R1)
    initial begin
        forever begin
            logic [8:0] v;
            @(negedge txd);
            repeat (DIV / 2) @(posedge clk);
            #1 chk(txd == 1'b0, "R1 start bit", int'(txd), 0);
            for (int i = 0; i < 9; i++) begin
                repeat (DIV) @(posedge clk);
                #1 v[i] = txd;
            end
            repeat (DIV) @(posedge clk);
            #1 chk(txd == 1'b1, "R1 stop bit", int'(txd), 1);
            txlog[tx_n] = v;
            tx_n++;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                rxq[rx_n] = rx_byte;
                rxf[rx_n] = rx_first;
                rx_n++;
            end
            if (tx_odd_err)   odd_cnt++;
            if (rx_frame_err) ferr_cnt++;
        end
    end

    task automatic send_byte(input logic [7:0] b, input logic last);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1;
        tx_byte  = b;
        tx_last  = last;
        @(negedge clk);
        tx_valid = 1'b0;
        tx_last  = 1'b0;
    endtask

    task automatic send_pair(input logic ninth, input logic [7:0] d);
        send_byte({7'b0, ninth}, 1'b0);
        send_byte(d, 1'b0);
    endtask

    task automatic drive_frame(input logic [8:0] v, input logic stopb);
        @(negedge clk);
        tb_rx = 1'b0;
        repeat (DIV) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            tb_rx = v[i];
            repeat (DIV) @(negedge clk);
        end
        tb_rx = stopb;
        repeat (DIV) @(negedge clk);
        tb_rx = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0, t0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(txd == 1'b1, "R11 txd idle", int'(txd), 1);
        chk(tx_ready == 1'b1, "R11 tx_ready", int'(tx_ready), 1);
        chk(rx_valid == 1'b0, "R11 rx_valid", int'(rx_valid), 0);
        chk(!tx_odd_err && !rx_frame_err, "R11 error flags",
            int'({tx_odd_err, rx_frame_err}), 0);

        // Table walk: per-character mode through the station filter (R3, R6, R7)
        for (int k = 0; k < 8; k++) begin
            n0 = rx_n;
            t0 = tx_n;
            send_pair(VEC[k][8], VEC[k][7:0]);
            repeat (WAITC) @(negedge clk);
            chk(tx_n == t0 + 1 && txlog[t0] == VEC[k][8:0], "R3 line char",
                int'(txlog[t0]), int'(VEC[k][8:0]));
            if (VEC[k][9]) begin
                chk(rx_n == n0 + 2 && rxf[n0] && rxq[n0] == {7'b0, VEC[k][8]},
                    "R6 kept flag byte", int'(rxq[n0]), int'(VEC[k][8]));
                chk(rx_n == n0 + 2 && !rxf[n0 + 1] && rxq[n0 + 1] == VEC[k][7:0],
                    "R4 kept data byte", int'(rxq[n0 + 1]), int'(VEC[k][7:0]));
            end else begin
                chk(rx_n == n0, "R7 dropped char", rx_n - n0, 0);
            end
        end

        // R10 / R5: loopback with the filter off
        filt_en = 1'b0;
        n0 = rx_n;
        send_pair(1'b0, 8'h55);
        send_pair(1'b1, 8'h55);
        send_pair(1'b0, 8'h55);
        repeat (WAITC) @(negedge clk);
        chk(rx_n == n0 + 6, "R10 byte count", rx_n - n0, 6);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] e;
            e = (i % 2 == 1) ? 8'h55 : ((i == 2) ? 8'h01 : 8'h00);
            chk(rxq[n0 + i] == e, "R10 byte value", int'(rxq[n0 + i]), int'(e));
        end

        // R2: block mode, a three-byte block then a one-byte block
        tx_mode_arb = 1'b0;
        t0 = tx_n;
        n0 = rx_n;
        send_byte(8'hA1, 1'b0);
        send_byte(8'hB2, 1'b0);
        send_byte(8'hC3, 1'b1);
        send_byte(8'hD4, 1'b1);
        repeat (WAITC) @(negedge clk);
        chk(tx_n == t0 + 4, "R2 char count", tx_n - t0, 4);
        chk(txlog[t0]     == 9'h1A1, "R2 block start", int'(txlog[t0]), 'h1A1);
        chk(txlog[t0 + 1] == 9'h0B2, "R2 mid block", int'(txlog[t0 + 1]), 'h0B2);
        chk(txlog[t0 + 2] == 9'h0C3, "R2 block end", int'(txlog[t0 + 2]), 'h0C3);
        chk(txlog[t0 + 3] == 9'h1D4, "R2 next block start", int'(txlog[t0 + 3]), 'h1D4);
        chk(rx_n == n0 + 8 && rxq[n0 + 2] == 8'h00 && rxq[n0 + 6] == 8'h01,
            "R5 unfiltered delivery", rx_n - n0, 8);

        // R9: odd request rejected, then a clean pair
        tx_mode_arb = 1'b1;
        t0 = tx_n;
        send_byte(8'h01, 1'b1);
        repeat (WAITC) @(negedge clk);
        chk(odd_cnt == 1, "R9 odd flag", odd_cnt, 1);
        chk(tx_n == t0, "R9 nothing sent", tx_n - t0, 0);
        send_pair(1'b1, 8'h5A);
        repeat (WAITC) @(negedge clk);
        chk(tx_n == t0 + 1 && txlog[t0] == 9'h15A, "R9 fresh pair",
            int'(txlog[t0]), 'h15A);

        // R1 receive side: externally driven frame, bit order
        lb = 1'b0;
        n0 = rx_n;
        drive_frame(9'h1C3, 1'b1);
        repeat (3 * DIV) @(negedge clk);
        chk(rx_n == n0 + 2 && rxq[n0] == 8'h01 && rxq[n0 + 1] == 8'hC3,
            "R1 receive order", int'(rxq[n0 + 1]), 'hC3);

        // R8: low stop bit
        n0 = rx_n;
        drive_frame(9'h0E7, 1'b0);
        repeat (3 * DIV) @(negedge clk);
        chk(ferr_cnt == 1, "R8 framing flag", ferr_cnt, 1);
        chk(rx_n == n0, "R8 char dropped", rx_n - n0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule